// File: doc/BRIEF.md
# Packet Header Deframer

This block takes 64-bit packets arriving on a valid/ready input stream and splits each one into a decoded header and a payload stream. The opening beat of every packet is a header word carrying a packet kind, a time-present flag, an end-of-burst flag, a sequence number, a byte length and two 16-bit stream identifiers. When the time-present flag is set, the beat that follows is taken as a 64-bit timestamp and kept off the payload stream. Every later beat is forwarded on the output stream unchanged, with its last marker.

The decoded fields are shown on a sideband bus guarded by `meta_valid`. The bus stays constant for the whole time the packet's payload is leaving the block, so a consumer can route or tag payload beats as they go. A length mismatch is reported by a one-cycle `len_err` pulse. The packet itself is never dropped or altered.

Back-pressure rules: `s_tready` is high while the block waits for a header or a timestamp. During the payload it equals `m_tready`. It is low for the one cycle a header-only packet holds the sideband. `m_tvalid` is only ever high together with `meta_valid`. A beat moves on a port only in a cycle where valid and ready are both high.

Top module: `pkt_hdr_strip`

## Requirements
- R1: Header word fields decode from fixed positions: [63:62] kind, [61] time-present, [60] end-of-burst, [59:48] sequence, [47:32] length in bytes, [31:16] source id, [15:0] destination id. They appear on the matching sideband outputs.
- R2: `meta_kind` uses the code 0 for data, 1 for flow control, 2 for command and 3 for response, taken unchanged from header bits [63:62].
- R3: When time-present is 1, the second beat appears on `meta_ts` and is not forwarded on the output stream.
- R4: When time-present is 0, `meta_ts` reads zero while `meta_valid` is high.
- R5: Payload beats leave in arrival order with data and last marker unchanged. No beat is lost, duplicated or invented.
- R6: `meta_valid` rises in the cycle after the header beat is accepted, or after the timestamp beat when one is present. The sideband stays constant while valid. It falls in the cycle after the payload's last beat is handed off.
- R7: A packet that ends on its header, or on its timestamp, produces no payload beats and holds `meta_valid` high for exactly one cycle.
- R8: Let N be the number of beats in a packet, counting header, timestamp and payload. The length is accepted if it equals 8·N or 8·N−4. Otherwise `len_err` is high for one cycle, the cycle in which `meta_valid` falls. The packet is still forwarded in full.
- R9: While `meta_valid` is high and `m_tready` is low, `s_tready` is low.
- R10: A synchronous active-high `rst` returns the block to waiting for a header: `meta_valid`, `m_tvalid` and `len_err` are low and `s_tready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | 64 | Input stream data |
| s_tvalid | input | 1 | Input beat valid |
| s_tlast | input | 1 | Input beat ends packet |
| s_tready | output | 1 | Block accepts input beat |
| m_tdata | output | 64 | Payload stream data |
| m_tvalid | output | 1 | Payload beat valid |
| m_tlast | output | 1 | Payload beat ends packet |
| m_tready | input | 1 | Downstream accepts payload beat |
| meta_valid | output | 1 | Sideband fields valid |
| meta_kind | output | 2 | Packet kind code |
| meta_has_time | output | 1 | Timestamp present |
| meta_eob | output | 1 | End-of-burst flag |
| meta_seq | output | 12 | Sequence number |
| meta_len | output | 16 | Length field in bytes |
| meta_src | output | 16 | Source identifier |
| meta_dst | output | 16 | Destination identifier |
| meta_ts | output | 64 | Timestamp, zero when absent |
| len_err | output | 1 | One-cycle length mismatch pulse |

## Verification
The hardest case to reach is a short packet arriving right after the previous one closes. This can be a header-only packet, or one that carries a timestamp but no payload. The input may also stall while the output is stalled at random. These are the moments when the sideband hold cycle, the length pulse and the next header can collide.

The stimulus sends packets back to back with random input bubbles and random downstream stalls. It includes header-only packets, timestamp-only packets, half-used last beats and wrong lengths. It also applies a reset in the middle of a packet. A scoreboard matches payload beats, sideband contents and the timing of each length pulse against what each sent packet implies.

// File: rtl/pkt_hdr_pkg.sv
package pkt_hdr_pkg;
  localparam int WORD_W = 64;
  localparam int SEQ_W  = 12;
  localparam int LEN_W  = 16;
  localparam int ID_W   = 16;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_FLOW = 2'd1,
    KIND_CMD  = 2'd2,
    KIND_RESP = 2'd3
  } pkt_kind_e;

  typedef struct packed {
    pkt_kind_e        kind;
    logic             has_time;
    logic             eob;
    logic [SEQ_W-1:0] seq;
    logic [LEN_W-1:0] len;
    logic [ID_W-1:0]  src;
    logic [ID_W-1:0]  dst;
  } hdr_fields_t;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_TS   = 2'd1,
    ST_BODY = 2'd2,
    ST_HOLD = 2'd3
  } strip_state_e;
endpackage

// File: rtl/hdr_unpack.sv
module hdr_unpack
  import pkt_hdr_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_fields_t       fields
);
  localparam int DST_LO = 0;
  localparam int SRC_LO = DST_LO + ID_W;
  localparam int LEN_LO = SRC_LO + ID_W;
  localparam int SEQ_LO = LEN_LO + LEN_W;
  localparam int EOB_B  = SEQ_LO + SEQ_W;
  localparam int TIME_B = EOB_B + 1;
  localparam int KIND_LO = TIME_B + 1;

  always_comb begin
    fields.kind     = pkt_kind_e'(word[KIND_LO +: 2]);
    fields.has_time = word[TIME_B];
    fields.eob      = word[EOB_B];
    fields.seq      = word[SEQ_LO +: SEQ_W];
    fields.len      = word[LEN_LO +: LEN_W];
    fields.src      = word[SRC_LO +: ID_W];
    fields.dst      = word[DST_LO +: ID_W];
  end
endmodule

// File: rtl/beat_len_check.sv
module beat_len_check
  import pkt_hdr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             first,
  input  logic             last,
  input  logic [LEN_W-1:0] len_in,
  output logic             bad_q
);
  localparam int BYTE_W = CNT_W + 3;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  total;
  logic [BYTE_W-1:0] bytes_full;
  logic [BYTE_W-1:0] bytes_half;
  logic [BYTE_W-1:0] len_ext;
  logic              len_ok;

  always_comb begin
    total      = first ? CNT_W'(1) : cnt_q + CNT_W'(1);
    bytes_full = {total, 3'b000};
    bytes_half = bytes_full - BYTE_W'(4);
    len_ext    = BYTE_W'(len_in);
    len_ok     = (len_ext == bytes_full) || (len_ext == bytes_half);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else if (beat) begin
      cnt_q <= total;
      if (last) bad_q <= !len_ok;
    end
  end

  // R8: the first counted beat of a packet always restarts the count at one
  assert_count_restart_R8: assert property (@(posedge clk) disable iff (rst)
    beat && first |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/strip_ctrl.sv
module strip_ctrl
  import pkt_hdr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic s_tvalid,
  input  logic s_tlast,
  input  logic hdr_has_time,
  input  logic m_tready,
  output logic s_tready,
  output logic m_tvalid,
  output logic meta_valid,
  output logic cap_hdr,
  output logic cap_ts,
  output logic first_beat,
  output logic closed_q
);
  strip_state_e st_q, st_d;
  logic         closing;

  always_comb begin
    s_tready   = 1'b0;
    m_tvalid   = 1'b0;
    meta_valid = 1'b0;
    first_beat = (st_q == ST_HDR);
    case (st_q)
      ST_HDR:  s_tready = 1'b1;
      ST_TS:   s_tready = 1'b1;
      ST_BODY: begin
        s_tready   = m_tready;
        m_tvalid   = s_tvalid;
        meta_valid = 1'b1;
      end
      default: meta_valid = 1'b1;
    endcase
    cap_hdr = (st_q == ST_HDR) && s_tvalid;
    cap_ts  = (st_q == ST_TS) && s_tvalid;
  end

  always_comb begin
    st_d    = st_q;
    closing = 1'b0;
    case (st_q)
      ST_HDR: if (s_tvalid) begin
        if (s_tlast)           st_d = ST_HOLD;
        else if (hdr_has_time) st_d = ST_TS;
        else                   st_d = ST_BODY;
      end
      ST_TS: if (s_tvalid) st_d = s_tlast ? ST_HOLD : ST_BODY;
      ST_BODY: if (s_tvalid && m_tready && s_tlast) begin
        st_d    = ST_HDR;
        closing = 1'b1;
      end
      default: begin
        st_d    = ST_HDR;
        closing = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_HDR;
      closed_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      closed_q <= closing;
    end
  end

  // R6: the sideband only turns on right after an accepted input beat
  assert_meta_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(meta_valid) |-> $past(s_tvalid && s_tready));

  // R9: a stalled output with an occupied sideband blocks the input
  assert_hold_input_R9: assert property (@(posedge clk) disable iff (rst)
    meta_valid && !m_tready |-> !s_tready);
endmodule

// File: rtl/pkt_hdr_strip.sv
module pkt_hdr_strip
  import pkt_hdr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  output logic [WORD_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_tlast,
  input  logic              m_tready,
  output logic              meta_valid,
  output logic [1:0]        meta_kind,
  output logic              meta_has_time,
  output logic              meta_eob,
  output logic [SEQ_W-1:0]  meta_seq,
  output logic [LEN_W-1:0]  meta_len,
  output logic [ID_W-1:0]   meta_src,
  output logic [ID_W-1:0]   meta_dst,
  output logic [WORD_W-1:0] meta_ts,
  output logic              len_err
);
  hdr_fields_t      in_fields;
  hdr_fields_t      hdr_q;
  logic [WORD_W-1:0] ts_q;
  logic             cap_hdr;
  logic             cap_ts;
  logic             first_beat;
  logic             closed_q;
  logic             bad_q;
  logic             in_beat;
  logic [LEN_W-1:0] len_sel;

  hdr_unpack u_unpack (
    .word   (s_tdata),
    .fields (in_fields)
  );

  strip_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .s_tvalid     (s_tvalid),
    .s_tlast      (s_tlast),
    .hdr_has_time (in_fields.has_time),
    .m_tready     (m_tready),
    .s_tready     (s_tready),
    .m_tvalid     (m_tvalid),
    .meta_valid   (meta_valid),
    .cap_hdr      (cap_hdr),
    .cap_ts       (cap_ts),
    .first_beat   (first_beat),
    .closed_q     (closed_q)
  );

  assign in_beat = s_tvalid && s_tready;
  assign len_sel = first_beat ? in_fields.len : hdr_q.len;

  beat_len_check #(.CNT_W(CNT_W)) u_len (
    .clk    (clk),
    .rst    (rst),
    .beat   (in_beat),
    .first  (first_beat),
    .last   (s_tlast),
    .len_in (len_sel),
    .bad_q  (bad_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q <= '0;
      ts_q  <= '0;
    end else if (cap_hdr) begin
      hdr_q <= in_fields;
      ts_q  <= '0;
    end else if (cap_ts) begin
      ts_q  <= s_tdata;
    end
  end

  assign m_tdata       = s_tdata;
  assign m_tlast       = s_tlast;
  assign meta_kind     = hdr_q.kind;
  assign meta_has_time = hdr_q.has_time;
  assign meta_eob      = hdr_q.eob;
  assign meta_seq      = hdr_q.seq;
  assign meta_len      = hdr_q.len;
  assign meta_src      = hdr_q.src;
  assign meta_dst      = hdr_q.dst;
  assign meta_ts       = ts_q;
  assign len_err       = closed_q && bad_q;

  // R6: sideband contents do not move while it is valid
  assert_meta_stable_R6: assert property (@(posedge clk) disable iff (rst)
    meta_valid && $past(meta_valid) |-> $stable({meta_kind, meta_has_time, meta_eob,
      meta_seq, meta_len, meta_src, meta_dst, meta_ts}));

  // R4: no timestamp means a zero timestamp
  assert_ts_zero_R4: assert property (@(posedge clk) disable iff (rst)
    meta_valid && !meta_has_time |-> meta_ts == '0);

  // R5: payload only leaves with a valid sideband beside it
  assert_payload_tagged_R5: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> meta_valid);

  // R8: the length pulse lands exactly where the sideband drops
  assert_err_at_close_R8: assert property (@(posedge clk) disable iff (rst)
    len_err |-> !meta_valid && $past(meta_valid));
endmodule

// File: tb/pkt_hdr_strip_test.sv
module pkt_hdr_strip_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tlast = 1'b0;
  logic        s_tready;
  logic [63:0] m_tdata;
  logic        m_tvalid;
  logic        m_tlast;
  logic        m_tready = 1'b1;
  logic        meta_valid;
  logic [1:0]  meta_kind;
  logic        meta_has_time;
  logic        meta_eob;
  logic [11:0] meta_seq;
  logic [15:0] meta_len;
  logic [15:0] meta_src;
  logic [15:0] meta_dst;
  logic [63:0] meta_ts;
  logic        len_err;

  int checks = 0;
  int errors = 0;
  int stall_mode = 0;
  int bubble_mode = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  logic [64:0]  pay_q[$];
  logic [127:0] meta_q[$];
  logic [1:0]   close_q[$];

  always #2 clk = ~clk;

  pkt_hdr_strip uut (
    .clk(clk), .rst(rst),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
    .meta_valid(meta_valid), .meta_kind(meta_kind), .meta_has_time(meta_has_time),
    .meta_eob(meta_eob), .meta_seq(meta_seq), .meta_len(meta_len), .meta_src(meta_src),
    .meta_dst(meta_dst), .meta_ts(meta_ts), .len_err(len_err)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    #1;
    m_tready = (stall_mode != 0) ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic push_beat(input logic [63:0] d, input logic l);
    bit hs;
    if (bubble_mode != 0) begin
      while (($urandom % 3) == 0) begin
        @(posedge clk);
        #1;
      end
    end
    s_tvalid = 1'b1;
    s_tdata  = d;
    s_tlast  = l;
    hs = 1'b0;
    while (!hs) begin
      @(negedge clk);
      hs = s_tready;
      @(posedge clk);
      #1;
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  // adj: 0 exact length, 1 half-used last beat, 2 wrong length
  task automatic send_pkt(input logic [1:0] kind, input logic ht, input logic eob,
                          input logic [11:0] seq, input int npay, input int adj,
                          input logic [15:0] src, input logic [15:0] dst, input logic [63:0] ts);
    int total;
    logic [15:0] len;
    logic [63:0] hw;
    total = 1 + (ht ? 1 : 0) + npay;
    len = 16'(8 * total);
    if (adj == 1) len = len - 16'd4;
    if (adj == 2) len = len + 16'd8;
    hw = {kind, ht, eob, seq, len, src, dst};
    meta_q.push_back({hw, ht ? ts : 64'h0});
    close_q.push_back({npay != 0, adj == 2});
    for (int i = 0; i < npay; i++)
      pay_q.push_back({i == npay - 1, {seq, 4'h0, src, dst, 16'(i)} ^ 64'hA5A5_0000_0000_5A5A});
    push_beat(hw, total == 1);
    if (ht) push_beat(ts, npay == 0);
    for (int i = 0; i < npay; i++)
      push_beat({seq, 4'h0, src, dst, 16'(i)} ^ 64'hA5A5_0000_0000_5A5A, i == npay - 1);
  endtask

  // scoreboard monitor, sampling at the falling edge
  initial begin
    bit mv_prev = 1'b0;
    bit saw_last = 1'b0;
    int mv_cnt = 0;
    forever begin
      @(negedge clk);
      if (!mon_en) begin
        mv_prev = 1'b0; saw_last = 1'b0; mv_cnt = 0;
      end else begin
        if (m_tvalid && m_tready) begin
          if (pay_q.size() == 0) check(1'b0, "R5 unexpected payload", {m_tlast, m_tdata}, 0);
          else begin
            logic [64:0] e;
            e = pay_q.pop_front();
            check({m_tlast, m_tdata} === e, "R5/R3 payload", {m_tlast, m_tdata}, e);
            if (m_tlast) saw_last = 1'b1;
          end
        end
        if (meta_valid && !m_tready) check(!s_tready, "R9 input blocked", s_tready, 0);
        if (meta_valid && !mv_prev) begin
          if (meta_q.size() == 0) check(1'b0, "R6 unexpected sideband", 1, 0);
          else begin
            logic [127:0] e;
            e = meta_q.pop_front();
            check(meta_kind === e[127:126], "R2 kind", meta_kind, e[127:126]);
            check({meta_has_time, meta_eob, meta_seq, meta_len, meta_src, meta_dst} === e[125:64],
                  "R1 fields", {meta_has_time, meta_eob, meta_seq, meta_len, meta_src, meta_dst}, e[125:64]);
            check(meta_ts === e[63:0], meta_has_time ? "R3 timestamp" : "R4 zero timestamp", meta_ts, e[63:0]);
          end
          mv_cnt = 0;
        end
        if (meta_valid) mv_cnt++;
        if (!meta_valid && mv_prev) begin
          if (close_q.size() == 0) check(1'b0, "R6 unexpected close", 1, 0);
          else begin
            logic [1:0] c;
            c = close_q.pop_front();
            check(len_err === c[0], "R8 length flag", len_err, c[0]);
            if (c[1]) check(saw_last, "R6 close after last payload", saw_last, 1);
            else check(mv_cnt == 1, "R7 one-cycle sideband", mv_cnt, 1);
          end
          saw_last = 1'b0;
        end else if (len_err) begin
          check(1'b0, "R8 stray length pulse", 1, 0);
        end
        mv_prev = meta_valid;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drain();
    int n = 0;
    while ((pay_q.size() != 0 || meta_q.size() != 0 || close_q.size() != 0) && n < 2000) begin
      @(posedge clk);
      n++;
    end
    repeat (4) @(posedge clk);
    #1;
    check(pay_q.size() == 0 && meta_q.size() == 0 && close_q.size() == 0, "R5 drain",
          pay_q.size() + meta_q.size() + close_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    check(s_tready === 1'b1, "R10 reset ready", s_tready, 1);
    check(meta_valid === 1'b0 && m_tvalid === 1'b0 && len_err === 1'b0, "R10 reset outputs",
          {meta_valid, m_tvalid, len_err}, 0);
    @(posedge clk);
    #1;
    mon_en = 1'b1;

    send_pkt(2'd0, 1'b0, 1'b0, 12'h001, 3, 0, 16'h1111, 16'h2222, 64'h0);
    send_pkt(2'd2, 1'b1, 1'b1, 12'h002, 2, 1, 16'h3333, 16'h4444, 64'hDEAD_BEEF_0123_4567);
    send_pkt(2'd1, 1'b0, 1'b0, 12'h003, 0, 0, 16'h5555, 16'h6666, 64'h0);
    send_pkt(2'd3, 1'b1, 1'b0, 12'h004, 0, 0, 16'h7777, 16'h8888, 64'hFEED_FACE_CAFE_0001);
    send_pkt(2'd0, 1'b0, 1'b1, 12'hFFF, 1, 2, 16'hFFFF, 16'h0000, 64'h0);
    send_pkt(2'd1, 1'b0, 1'b0, 12'h006, 0, 2, 16'h0101, 16'h0202, 64'h0);
    drain();

    stall_mode = 1;
    bubble_mode = 1;
    for (int p = 0; p < 24; p++)
      send_pkt(2'(p), 1'((p / 2) % 2), 1'(p % 3 == 0), 12'(16 + p), p % 5, p % 3,
               16'(p * 17), 16'(p * 29), {32'(p), 32'h0BAD_F00D});
    drain();

    bubble_mode = 0;
    for (int p = 0; p < 6; p++)
      send_pkt(2'(p), 1'(p % 2), 1'b0, 12'(64 + p), (p < 3) ? 0 : 2, 0,
               16'(p), 16'(p + 1), 64'h1234_0000 + 64'(p));
    drain();
    stall_mode = 0;

    // reset in the middle of a packet: header with timestamp flag, then reset
    mon_en = 1'b0;
    push_beat({2'd2, 1'b1, 1'b0, 12'h0AA, 16'd24, 16'h0001, 16'h0002}, 1'b0);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    check(s_tready === 1'b1 && meta_valid === 1'b0 && len_err === 1'b0, "R10 mid-packet reset",
          {s_tready, meta_valid, len_err}, 3'b100);
    @(posedge clk);
    #1;
    mon_en = 1'b1;
    send_pkt(2'd0, 1'b0, 1'b0, 12'h0BB, 2, 0, 16'h0A0A, 16'h0B0B, 64'h0);
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule